// File: doc/BRIEF.md
# Register-Mapped Byte RAM Loader

This block fills a byte-wide code memory through a 16-bit register port. A host picks a register by a 5-bit address, then writes a word or reads one back. A pointer register selects the memory byte to access. A data register moves bytes to and from the memory at that pointer. A mode register picks one of two widths for the data register. In byte mode, each data access moves a single byte and the pointer does not move. In word mode, each 16-bit data write becomes two byte stores at consecutive addresses, low byte first, and the pointer advances after each store. This lets a host stream a whole image with one register write per two bytes.

The memory occupies a window of the 16-bit address space that starts at `RAM_BASE` and spans `RAM_BYTES` bytes. A control register holds a power-down bit, which is driven out as `core_hold` so that the host can keep the core quiet while it loads code. A start register records the address where execution begins and raises `exec_start` for one cycle.

Word-mode writes are run by a small state machine with three states. `ST_IDLE` accepts requests. An accepted word-mode data write moves it to `ST_PUT_LO`, which stores the low byte and bumps the pointer. `ST_PUT_LO` always moves on to `ST_PUT_HI`, which stores the high byte, bumps the pointer again and returns to `ST_IDLE`. Requests are accepted only in `ST_IDLE`.

Top module: `code_ram_loader`

## Requirements
- R1: After reset the pointer is 0x0000, the mode register is 0x0000 (byte mode), `core_hold`, `exec_start` and `reg_rvalid` are low, `exec_addr` is 0, and `reg_ready` is high.
- R2: A write to register 0x1E loads the pointer, and a read of 0x1E returns the current pointer.
- R3: In byte mode, a write to 0x1D stores `reg_wdata[7:0]` at the pointer and leaves the pointer unchanged. A byte-mode read of 0x1D returns {0x00, byte at the pointer} and leaves the pointer unchanged.
- R4: Register 0x16 is readable. Word mode is active only while it holds exactly 0x0006; any other value gives byte mode.
- R5: In word mode, a write to 0x1D stores the low byte at the pointer and the high byte at the pointer plus one, and leaves the pointer two higher. Back-to-back writes fill consecutive bytes.
- R6: After a word-mode data write is accepted, `reg_ready` is low for exactly two cycles. A request held during that time is accepted in the first cycle that `reg_ready` is high again, and it sees the final pointer.
- R7: In word mode, a read of 0x1D returns {byte at pointer+1, byte at pointer} and advances the pointer by two.
- R8: A byte address outside [RAM_BASE, RAM_BASE+RAM_BYTES) is never stored to, and the pointer still advances. Bytes read from outside the window read as 0x00.
- R9: A write to 0x1F latches `reg_wdata` on `exec_addr`, which reads back at 0x1F. `exec_start` is high for exactly the one cycle after the write is accepted.
- R10: Bit 11 of register 0x00 is the power-down bit. It drives `core_hold`, and register 0x00 reads back with only bit 11 possibly set.
- R11: Read data is returned with `reg_rvalid` high in the cycle after the read is accepted. Unmapped addresses read as 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_req | input | 1 | Register access request, accepted when `reg_ready` is high |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_ready | output | 1 | High when a request can be accepted |
| reg_rvalid | output | 1 | Read data valid, one cycle after an accepted read |
| reg_rdata | output | 16 | Read data |
| core_hold | output | 1 | Power-down bit, holds the core off during loading |
| exec_addr | output | 16 | Latched execution start address |
| exec_start | output | 1 | One-cycle start pulse |

## Verification
The checker watches every cycle for the following properties:
- the two-cycle busy window after each word write;
- stores that never fall outside the memory window;
- the pointer load;
- the power-down bit following its write;
- a start pulse and read-valid flag that appear only after their own accepted request.

Memory contents and byte order can only be shown by the bench's scenarios. These cover a full fill of a small memory in both modes with read-back, the stall of a held request, word writes that straddle both edges of the window, and the exact value that the mode register needs.

// File: rtl/crl_pkg.sv
package crl_pkg;
    localparam logic [4:0]  RA_CTRL  = 5'h00;
    localparam logic [4:0]  RA_MODE  = 5'h16;
    localparam logic [4:0]  RA_DATA  = 5'h1D;
    localparam logic [4:0]  RA_PTR   = 5'h1E;
    localparam logic [4:0]  RA_START = 5'h1F;
    localparam logic [15:0] WORD_MODE_KEY = 16'h0006;
    localparam int          PDN_BIT  = 11;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PUT_LO,
        ST_PUT_HI
    } ld_state_e;
endpackage

// File: rtl/crl_window.sv
module crl_window #(
    parameter logic [15:0] BASE  = 16'h8400,
    parameter int          BYTES = 1024,
    localparam int         IW    = $clog2(BYTES)
) (
    input  logic [15:0]   addr,
    output logic          hit,
    output logic [IW-1:0] idx
);
    logic [16:0] off;

    always_comb begin
        off = {1'b0, addr} - {1'b0, BASE};
        hit = (addr >= BASE) && (off < 17'(BYTES));
        idx = off[IW-1:0];
    end
endmodule

// File: rtl/crl_byte_ram.sv
module crl_byte_ram #(
    parameter int  DEPTH = 1024,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] ra0,
    input  logic [AW-1:0] ra1,
    output logic [7:0]    rd0,
    output logic [7:0]    rd1
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rd0 = mem[ra0];
    assign rd1 = mem[ra1];
endmodule

// File: rtl/crl_ctrl.sv
module crl_ctrl
    import crl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic        we,
    input  logic [4:0]  addr,
    input  logic [15:0] wdata,
    output logic        ready,
    output logic        rvalid,
    output logic [15:0] rdata,
    input  logic        hit0,
    input  logic        hit1,
    input  logic [7:0]  rbyte0,
    input  logic [7:0]  rbyte1,
    output logic        ram_we,
    output logic [7:0]  ram_wdata,
    output logic [15:0] ptr,
    output logic        word_mode,
    output logic        core_hold,
    output logic [15:0] exec_addr,
    output logic        exec_start
);
    ld_state_e   state_q, state_d;
    logic [15:0] ptr_q, ptr_d;
    logic [15:0] hold_q;
    logic [15:0] mode_q;
    logic        pdn_q;
    logic [15:0] exec_q;
    logic        start_q;
    logic [15:0] rdata_q, rdata_d;
    logic        rvalid_q;
    logic        accept, wr_acc, rd_acc;
    logic [7:0]  lo_byte, hi_byte;

    assign word_mode = (mode_q == WORD_MODE_KEY);
    assign accept    = req && (state_q == ST_IDLE);
    assign wr_acc    = accept && we;
    assign rd_acc    = accept && !we;
    assign lo_byte   = hit0 ? rbyte0 : 8'h00;
    assign hi_byte   = hit1 ? rbyte1 : 8'h00;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state, pointer and memory strobes
    always_comb begin
        state_d   = state_q;
        ptr_d     = ptr_q;
        ram_we    = 1'b0;
        ram_wdata = 8'h00;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_acc && addr == RA_DATA) begin
                    if (word_mode) begin
                        state_d = ST_PUT_LO;
                    end else begin
                        ram_we    = hit0;
                        ram_wdata = wdata[7:0];
                    end
                end else if (wr_acc && addr == RA_PTR) begin
                    ptr_d = wdata;
                end else if (rd_acc && addr == RA_DATA && word_mode) begin
                    ptr_d = ptr_q + 16'd2;
                end
            end
            ST_PUT_LO: begin
                ram_we    = hit0;
                ram_wdata = hold_q[7:0];
                ptr_d     = ptr_q + 16'd1;
                state_d   = ST_PUT_HI;
            end
            ST_PUT_HI: begin
                ram_we    = hit0;
                ram_wdata = hold_q[15:8];
                ptr_d     = ptr_q + 16'd1;
                state_d   = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // read data selection
    always_comb begin
        unique case (addr)
            RA_CTRL:  rdata_d = 16'(pdn_q) << PDN_BIT;
            RA_MODE:  rdata_d = mode_q;
            RA_DATA:  rdata_d = word_mode ? {hi_byte, lo_byte} : {8'h00, lo_byte};
            RA_PTR:   rdata_d = ptr_q;
            RA_START: rdata_d = exec_q;
            default:  rdata_d = 16'h0000;
        endcase
    end

    // register file
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q    <= 16'h0000;
            hold_q   <= 16'h0000;
            mode_q   <= 16'h0000;
            pdn_q    <= 1'b0;
            exec_q   <= 16'h0000;
            start_q  <= 1'b0;
            rdata_q  <= 16'h0000;
            rvalid_q <= 1'b0;
        end else begin
            ptr_q    <= ptr_d;
            start_q  <= wr_acc && (addr == RA_START);
            rvalid_q <= rd_acc;
            if (rd_acc) rdata_q <= rdata_d;
            if (wr_acc) begin
                unique case (addr)
                    RA_CTRL:  pdn_q  <= wdata[PDN_BIT];
                    RA_MODE:  mode_q <= wdata;
                    RA_DATA:  hold_q <= wdata;
                    RA_START: exec_q <= wdata;
                    default:  ;
                endcase
            end
        end
    end

    assign ready      = (state_q == ST_IDLE);
    assign rvalid     = rvalid_q;
    assign rdata      = rdata_q;
    assign ptr        = ptr_q;
    assign core_hold  = pdn_q;
    assign exec_addr  = exec_q;
    assign exec_start = start_q;
endmodule

// File: rtl/code_ram_loader.sv
module code_ram_loader #(
    parameter logic [15:0] RAM_BASE  = 16'h8400,
    parameter int          RAM_BYTES = 1024,
    localparam int         AW        = $clog2(RAM_BYTES),
    localparam int         LANES     = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_req,
    input  logic        reg_we,
    input  logic [4:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic        reg_ready,
    output logic        reg_rvalid,
    output logic [15:0] reg_rdata,
    output logic        core_hold,
    output logic [15:0] exec_addr,
    output logic        exec_start
);
    logic [15:0]   ptr_w;
    logic          word_mode_w;
    logic          ram_we_w;
    logic [7:0]    ram_wdata_w;
    logic [LANES-1:0] hit_w;
    logic [AW-1:0] idx_w [LANES];
    logic [7:0]    rbyte_w [LANES];

    // lane 0 covers the pointer, lane 1 the pointer plus one
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [15:0] lane_addr;
        assign lane_addr = ptr_w + 16'(g);
        crl_window #(.BASE(RAM_BASE), .BYTES(RAM_BYTES)) u_win (
            .addr (lane_addr),
            .hit  (hit_w[g]),
            .idx  (idx_w[g])
        );
    end

    crl_byte_ram #(.DEPTH(RAM_BYTES)) u_ram (
        .clk   (clk),
        .we    (ram_we_w),
        .waddr (idx_w[0]),
        .wdata (ram_wdata_w),
        .ra0   (idx_w[0]),
        .ra1   (idx_w[1]),
        .rd0   (rbyte_w[0]),
        .rd1   (rbyte_w[1])
    );

    crl_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (reg_req),
        .we         (reg_we),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .ready      (reg_ready),
        .rvalid     (reg_rvalid),
        .rdata      (reg_rdata),
        .hit0       (hit_w[0]),
        .hit1       (hit_w[1]),
        .rbyte0     (rbyte_w[0]),
        .rbyte1     (rbyte_w[1]),
        .ram_we     (ram_we_w),
        .ram_wdata  (ram_wdata_w),
        .ptr        (ptr_w),
        .word_mode  (word_mode_w),
        .core_hold  (core_hold),
        .exec_addr  (exec_addr),
        .exec_start (exec_start)
    );
endmodule

// File: rtl/crl_chk.sv
module crl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req,
    input logic        we,
    input logic [4:0]  addr,
    input logic [15:0] wdata,
    input logic        ready,
    input logic        rvalid,
    input logic        start,
    input logic [15:0] exec_addr,
    input logic        hold,
    input logic [15:0] ptr,
    input logic        word_mode,
    input logic        ram_we,
    input logic        hit0
);
    logic acc_w;
    assign acc_w = req && ready && we;

    // R6
    word_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_w && addr == 5'h1D && word_mode |=> !ready ##1 !ready ##1 ready);

    // R9
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_w && addr == 5'h1F |=> start && exec_addr == $past(wdata));

    // R9
    start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> $past(acc_w && addr == 5'h1F));

    // R2
    ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_w && addr == 5'h1E |=> ptr == $past(wdata));

    // R8
    ram_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> hit0);

    // R10
    hold_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_w && addr == 5'h00 |=> hold == $past(wdata[11]));

    // R11
    rvalid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $past(req && ready && !we));
endmodule

bind code_ram_loader crl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (reg_req),
    .we        (reg_we),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .ready     (reg_ready),
    .rvalid    (reg_rvalid),
    .start     (exec_start),
    .exec_addr (exec_addr),
    .hold      (core_hold),
    .ptr       (ptr_w),
    .word_mode (word_mode_w),
    .ram_we    (ram_we_w),
    .hit0      (hit_w[0])
);

// File: tb/code_ram_loader_tb.sv
module code_ram_loader_tb;
    localparam int          NB   = 64;
    localparam logic [15:0] BASE = 16'h8400;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_req, reg_we;
    logic [4:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic        reg_ready, reg_rvalid;
    logic [15:0] reg_rdata;
    logic        core_hold;
    logic [15:0] exec_addr;
    logic        exec_start;

    int         n_chk = 0;
    int         n_bad = 0;
    logic [7:0] model [NB];
    logic [15:0] rv;
    logic        rvld;

    always #10 clk = ~clk;

    code_ram_loader #(.RAM_BASE(BASE), .RAM_BYTES(NB)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_ready(reg_ready),
        .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata), .core_hold(core_hold),
        .exec_addr(exec_addr), .exec_start(exec_start)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        while (!reg_ready) @(negedge clk);
        reg_req = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_req = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d, output logic v);
        @(negedge clk);
        while (!reg_ready) @(negedge clk);
        reg_req = 1'b1; reg_we = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_req = 1'b0;
        d = reg_rdata;
        v = reg_rvalid;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; reg_req = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 ready", reg_ready, 1);
        check("R1 start", exec_start, 0);
        check("R1 hold", core_hold, 0);
        check("R1 rvalid", reg_rvalid, 0);
        check("R1 exec_addr", exec_addr, 0);
        rst_n = 1'b1;
        rd(5'h1E, rv, rvld); check("R1 ptr", rv, 16'h0000);
        rd(5'h16, rv, rvld); check("R1 mode", rv, 16'h0000);

        // R10 power-down bit
        wr(5'h00, 16'h0800); check("R10 hold set", core_hold, 1);
        rd(5'h00, rv, rvld); check("R10 readback", rv, 16'h0800);
        wr(5'h00, 16'hF7FF); check("R10 hold clear", core_hold, 0);
        rd(5'h00, rv, rvld); check("R10 readback clear", rv, 16'h0000);
        wr(5'h00, 16'h0800);

        // R2 pointer
        wr(5'h1E, 16'h1234);
        rd(5'h1E, rv, rvld); check("R2 ptr", rv, 16'h1234);
        // R11 valid timing and unmapped read
        check("R11 rvalid", rvld, 1);
        @(negedge clk); check("R11 rvalid drop", reg_rvalid, 0);
        rd(5'h05, rv, rvld); check("R11 unmapped", rv, 16'h0000);

        // R3 byte mode fill
        for (int i = 0; i < NB; i++) begin
            model[i] = 8'(i * 37 + 11);
            wr(5'h1E, BASE + 16'(i));
            wr(5'h1D, {8'hEE, model[i]});
        end
        rd(5'h1E, rv, rvld); check("R3 ptr unchanged by write", rv, BASE + 16'(NB - 1));
        for (int i = 0; i < NB; i++) begin
            wr(5'h1E, BASE + 16'(i));
            rd(5'h1D, rv, rvld); check("R3 byte read", rv, {8'h00, model[i]});
        end
        rd(5'h1E, rv, rvld); check("R3 ptr unchanged by read", rv, BASE + 16'(NB - 1));

        // R4 mode key must be exact
        wr(5'h16, 16'h0007);
        rd(5'h16, rv, rvld); check("R4 mode readback", rv, 16'h0007);
        wr(5'h1E, BASE);
        rd(5'h1D, rv, rvld); check("R4 non-key is byte mode", rv, {8'h00, model[0]});
        wr(5'h16, 16'h0006);
        wr(5'h1E, BASE);
        rd(5'h1D, rv, rvld); check("R4 key gives word mode", rv, {model[1], model[0]});

        // R5 word fill
        wr(5'h1E, BASE);
        for (int w = 0; w < NB / 2; w++) begin
            logic [15:0] d;
            d = 16'(w * 16'h1357 + 16'h2468);
            model[2*w]   = d[7:0];
            model[2*w+1] = d[15:8];
            wr(5'h1D, d);
        end
        rd(5'h1E, rv, rvld); check("R5 ptr after fill", rv, BASE + 16'(NB));

        // R7 word read back
        wr(5'h1E, BASE);
        for (int w = 0; w < NB / 2; w++) begin
            rd(5'h1D, rv, rvld); check("R7 word read", rv, {model[2*w+1], model[2*w]});
        end
        rd(5'h1E, rv, rvld); check("R7 ptr after reads", rv, BASE + 16'(NB));

        // R5 byte order seen through byte mode
        wr(5'h16, 16'h0000);
        for (int i = 0; i < NB; i++) begin
            wr(5'h1E, BASE + 16'(i));
            rd(5'h1D, rv, rvld); check("R5 byte order", rv, {8'h00, model[i]});
        end
        wr(5'h16, 16'h0006);

        // R6 busy window and stall
        wr(5'h1E, BASE);
        wr(5'h1D, 16'hBEEF);
        model[0] = 8'hEF; model[1] = 8'hBE;
        check("R6 busy cycle 1", reg_ready, 0);
        reg_req = 1'b1; reg_we = 1'b0; reg_addr = 5'h1E;
        @(negedge clk); check("R6 busy cycle 2", reg_ready, 0);
        @(negedge clk); check("R6 ready again", reg_ready, 1);
        @(negedge clk); reg_req = 1'b0;
        check("R6 stalled read valid", reg_rvalid, 1);
        check("R6 stalled read ptr", reg_rdata, BASE + 16'd2);

        // R8 top edge of window
        wr(5'h1E, BASE + 16'(NB - 1));
        wr(5'h1D, 16'hA1B2);
        model[NB-1] = 8'hB2;
        rd(5'h1E, rv, rvld); check("R8 ptr past top", rv, BASE + 16'(NB + 1));
        wr(5'h1E, BASE + 16'(NB - 1));
        rd(5'h1D, rv, rvld); check("R8 top straddle", rv, {8'h00, model[NB-1]});
        // R8 bottom edge of window
        wr(5'h1E, BASE - 16'd1);
        wr(5'h1D, 16'hC3D4);
        model[0] = 8'hC3;
        rd(5'h1E, rv, rvld); check("R8 ptr past bottom", rv, BASE + 16'd1);
        wr(5'h1E, BASE - 16'd1);
        rd(5'h1D, rv, rvld); check("R8 bottom straddle", rv, {model[0], 8'h00});
        rd(5'h1D, rv, rvld); check("R8 neighbours intact", rv, {model[2], model[1]});

        // R9 start pulse
        wr(5'h1F, 16'h8400);
        check("R9 pulse", exec_start, 1);
        check("R9 addr", exec_addr, 16'h8400);
        @(negedge clk); check("R9 pulse ends", exec_start, 0);
        rd(5'h1F, rv, rvld); check("R9 readback", rv, 16'h8400);
        wr(5'h1F, 16'h8456);
        check("R9 second pulse", exec_start, 1);
        check("R9 second addr", exec_addr, 16'h8456);
        check("R10 hold kept", core_hold, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule